// File: doc/BRIEF.md
# SPI Daisy-Chain Frame Master

This block is the controller side of a serial peripheral chain in which several shift-register slaves are cascaded. Every slave sees the same chip-select and serial clock. The master's data output enters only the first slave. Each slave's output feeds the next slave, and the last slave's output returns to the master. On a start request the block sends one continuous frame. The frame length is the sum of the word lengths of all devices, and chip-select stays low for the whole frame. Once the frame has been clocked through, every slave holds its own command, and the master holds the status words that the slaves preloaded.

Command and status words are carried on flat buses with one slice per device. Device 0 is the slave nearest the master's data output, and its slice sits at the least significant end. Device k occupies `len_k` bits starting at the sum of the lengths of devices 0 to k-1. The number of devices, their word lengths, the serial clock half-period and the minimum idle time between frames are all parameters.

Top module: `spi_chain_master`

## Requirements
- R1: One frame gives exactly TOTAL rising `sclk_o` edges while `cs_no` is low, where TOTAL is the sum of all device lengths (32 with the default lengths 8, 8 and 16). `cs_no` stays low for exactly (2*TOTAL+1)*HALF_DIV clock cycles.
- R2: The slice of the farthest device (top bits of `cmd_i`) is sent first and the slice of device 0 (bits [len_0-1:0]) is sent last. At the end of the frame each slave holds its own slice.
- R3: The first bits received are placed in the farthest device's slice of `sts_o`. The last bits received are placed in device 0's slice, using the same layout as `cmd_i`.
- R4: Within each word the most significant bit is sent and received first.
- R5: `sclk_o` is low whenever `cs_no` is high, including the cycle in which `cs_no` falls.
- R6: `mosi_o` changes only together with a falling `sclk_o` edge, or at the falling edge of `cs_no`. `miso_i` is sampled in the cycle in which `sclk_o` rises.
- R7: `done_o` is a one-cycle pulse that occurs exactly one cycle after `cs_no` returns high. `sts_o` is updated in that cycle and holds its value until the next pulse.
- R8: Between frames `cs_no` stays high for at least IDLE_CYC+2 cycles. When `start_i` is held high, it stays high for exactly IDLE_CYC+2 cycles.
- R9: A `start_i` pulse during a frame or during the idle gap is ignored. It does not restart the frame and does not queue a further frame.
- R10: After reset `cs_no` is high, `sclk_o` and `mosi_o` are low, `done_o` is low and `sts_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, taken only when idle and the gap has expired |
| cmd_i | input | TOTAL | Concatenated per-device command words, device 0 lowest |
| miso_i | input | 1 | Serial data returning from the last slave |
| cs_no | output | 1 | Shared chip-select, active low |
| sclk_o | output | 1 | Shared serial clock, idles low |
| mosi_o | output | 1 | Serial data to the first slave |
| done_o | output | 1 | One-cycle pulse when the frame is finished and status is valid |
| sts_o | output | TOTAL | Concatenated per-device status words, device 0 lowest |

## Verification
The bench models the chain as one behavioural bit queue that is loaded with the slaves' status at the chip-select fall and clocked by the serial clock. The frame is tried with a pattern taken from mixed real traffic, with all-ones against all-zeros, with single set bits at both ends of the frame, and with pseudo-random words. The all-ones/all-zeros case separates data from stuck lines. The end-bit case exposes reversed device order or reversed bit order and off-by-one shifts. The random case catches misplaced slice offsets. A held start request checks the exact idle gap, and a start pulse in the middle of a frame shows that requests arriving while busy are ignored.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int MAX_DEV = 32;
  typedef logic [8*MAX_DEV-1:0] len_vec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_DONE
  } state_e;

  function automatic int len_at(len_vec_t v, int k);
    return int'(v[8*k +: 8]);
  endfunction

  // bit offset of device k = sum of lengths of devices below it
  function automatic int off_at(len_vec_t v, int k);
    int s = 0;
    for (int i = 0; i < k; i++) s += len_at(v, i);
    return s;
  endfunction

endpackage

// File: rtl/sdc_tick.sv
module sdc_tick #(
  parameter int HALF = 2,
  localparam int CW = $clog2(HALF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(HALF));

  // R1
  tick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/sdc_shifter.sv
module sdc_shifter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         sample_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);

  logic [W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= load_val_i;
      rx_q <= '0;
    end else begin
      if (shift_i)  tx_q <= {tx_q[W-2:0], 1'b0};
      if (sample_i) rx_q <= {rx_q[W-2:0], miso_i};
    end
  end

  assign mosi_o = tx_q[W-1];
  assign rx_o   = rx_q;

  // R6
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(mosi_o));

  // R6
  miso_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !load_i) |=> (rx_q[0] == $past(miso_i)));

endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
  import sdc_pkg::*;
#(
  parameter int                 N_DEV    = 3,
  parameter logic [8*N_DEV-1:0] DEV_LEN  = {8'd16, 8'd8, 8'd8},
  parameter int                 HALF_DIV = 2,
  parameter int                 IDLE_CYC = 5,
  localparam int                TOTAL    = off_at(len_vec_t'(DEV_LEN), N_DEV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TOTAL-1:0] cmd_i,
  input  logic             miso_i,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic [TOTAL-1:0] sts_o
);

  localparam int CW = $clog2(TOTAL + 1);
  localparam int GW = $clog2(IDLE_CYC + 2);

  state_e           st_q, st_d;
  logic             cs_n_q, sclk_q, done_q;
  logic [CW-1:0]    bit_q;
  logic [GW-1:0]    gap_q;
  logic [TOTAL-1:0] sts_q, rx, load_val;
  logic             tick, tick_en, load, shift, sample;

  assign tick_en = (st_q == ST_LOW) || (st_q == ST_HIGH) || (st_q == ST_HOLD);

  sdc_tick #(.HALF(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en),
    .tick_o (tick)
  );

  sdc_shifter #(.W(TOTAL)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .shift_i    (shift),
    .sample_i   (sample),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .rx_o       (rx)
  );

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    shift    = 1'b0;
    sample   = 1'b0;
    load_val = cmd_i;
    unique case (st_q)
      ST_IDLE: if (start_i && gap_q == '0) begin
        load = 1'b1;
        st_d = ST_LOW;
      end
      ST_LOW: if (tick) begin
        sample = 1'b1;
        st_d   = ST_HIGH;
      end
      ST_HIGH: if (tick) begin
        if (bit_q == CW'(TOTAL)) st_d = ST_HOLD;
        else begin
          shift = 1'b1;
          st_d  = ST_LOW;
        end
      end
      ST_HOLD: if (tick) st_d = ST_DONE;
      ST_DONE: begin
        load     = 1'b1;  // park data line low
        load_val = '0;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      bit_q  <= '0;
      gap_q  <= '0;
      sts_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      if (st_q == ST_IDLE && st_d == ST_LOW) begin
        cs_n_q <= 1'b0;
        bit_q  <= '0;
      end
      if (sample) begin
        sclk_q <= 1'b1;
        bit_q  <= bit_q + 1'b1;
      end
      if (st_q == ST_HIGH && tick) sclk_q <= 1'b0;
      if (st_q == ST_HOLD && tick) cs_n_q <= 1'b1;
      if (st_q == ST_DONE) begin
        sts_q  <= rx;
        done_q <= 1'b1;
        gap_q  <= GW'(IDLE_CYC);
      end else if (st_q == ST_IDLE && gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
      end
    end
  end

  assign cs_no  = cs_n_q;
  assign sclk_o = sclk_q;
  assign done_o = done_q;
  assign sts_o  = sts_q;

  // R5
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> !sclk_q);

  // R7
  done_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cs_n_q && $past(cs_n_q)));

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R1
  frame_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |-> (bit_q == CW'(TOTAL)));

  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_q && start_i) |=> !$rose(cs_n_q) || (st_q == ST_DONE));

endmodule

// File: tb/tb_spi_chain_master.sv
module tb_spi_chain_master;

  localparam int HALF  = 2;
  localparam int IDLE  = 5;
  localparam int TOTAL = 32;

  logic             clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
  logic [TOTAL-1:0] cmd = '0, stat = '0;
  logic             cs_n, sclk, mosi, done;
  logic [TOTAL-1:0] sts;

  always #4 clk = ~clk;

  spi_chain_master #(
    .N_DEV(3), .DEV_LEN({8'd16, 8'd8, 8'd8}), .HALF_DIV(HALF), .IDLE_CYC(IDLE)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .miso_i(miso),
    .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi), .done_o(done), .sts_o(sts)
  );

  int errs = 0, checks = 0, cyc = 0;
  int rises = 0, nfall = 0, ndone = 0;
  int fall_cyc = 0, rise_cyc = 0;
  bit gap_mode = 1'b0;
  bit chain_q[$];
  logic p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0, p_done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  // whole chain behaves as one TOTAL-bit register; front = last slave's output
  always @(negedge cs_n) begin
    chain_q.delete();
    for (int i = TOTAL - 1; i >= 0; i--) chain_q.push_back(stat[i]);
    miso  = chain_q[0];
    rises = 0;
  end

  always @(posedge sclk) if (!cs_n) begin
    rises++;
    void'(chain_q.pop_front());
    chain_q.push_back(mosi);
    miso = chain_q[0];
  end

  always @(negedge clk) if (rst_n) begin
    logic [TOTAL-1:0] got;
    // R5
    if (cs_n) chk(!sclk, "R5 sclk low with cs high", sclk, 0);
    // R6
    if (!cs_n && !p_cs && mosi !== p_mosi)
      chk(p_sclk && !sclk, "R6 mosi moved off falling edge", {p_sclk, sclk}, 2'b10);
    if (!cs_n && p_cs) begin
      nfall++;
      if (gap_mode) chk(cyc - rise_cyc == IDLE + 2, "R8 idle gap", cyc - rise_cyc, IDLE + 2);
      fall_cyc = cyc;
    end
    if (cs_n && !p_cs) begin
      rise_cyc = cyc;
      chk(cyc - fall_cyc == (2*TOTAL+1)*HALF, "R1 cs low length", cyc - fall_cyc, (2*TOTAL+1)*HALF);
      chk(rises == TOTAL, "R1 sclk edge count", rises, TOTAL);
      for (int i = 0; i < TOTAL; i++) got[TOTAL-1-i] = chain_q[i];
      // R2 order of devices, R4 msb first: each slave holds its own slice
      chk(got[31:16] == cmd[31:16], "R2 R4 far device word", got[31:16], cmd[31:16]);
      chk(got[15:8]  == cmd[15:8],  "R2 R4 middle device word", got[15:8], cmd[15:8]);
      chk(got[7:0]   == cmd[7:0],   "R2 R4 near device word", got[7:0], cmd[7:0]);
    end
    if (done) begin
      ndone++;
      chk(cs_n && (cyc - rise_cyc == 1), "R7 done timing", cyc - rise_cyc, 1);
      chk(!p_done, "R7 done width", p_done, 0);
      chk(sts == stat, "R3 R4 status split", sts, stat);
    end
    p_cs = cs_n; p_sclk = sclk; p_mosi = mosi; p_done = done;
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk(1'b0, "R7 done missing", 0, 1);
    @(negedge clk);
  endtask

  task automatic frame(input logic [TOTAL-1:0] c, input logic [TOTAL-1:0] s);
    repeat (IDLE + 2) @(negedge clk);
    cmd = c; stat = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  initial begin
    logic [31:0] lcg;
    int nf;
    repeat (3) @(negedge clk);
    // R10
    chk(cs_n == 1'b1, "R10 cs after reset", cs_n, 1);
    chk(sclk == 1'b0, "R10 sclk after reset", sclk, 0);
    chk(mosi == 1'b0, "R10 mosi after reset", mosi, 0);
    chk(done == 1'b0, "R10 done after reset", done, 0);
    chk(sts == '0, "R10 sts after reset", sts, 0);
    rst_n = 1'b1;

    frame({16'h0000, 8'h4F, 8'h33}, {16'hFDFE, 8'hC6, 8'hDF});
    frame(32'hFFFF_FFFF, 32'h0000_0000);
    frame(32'h0000_0000, 32'hFFFF_FFFF);
    frame(32'h8000_0001, 32'h0001_8000);
    lcg = 32'h1234_5678;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      frame(a, lcg);
    end

    // R7 status holds after the pulse
    repeat (20) @(negedge clk);
    chk(sts == stat, "R7 status held", sts, stat);

    // R9 start during a frame is ignored
    repeat (IDLE + 2) @(negedge clk);
    nf = nfall;
    cmd = 32'hA5C3_3C5A; stat = 32'h0F0F_F0F0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (IDLE + 30) @(negedge clk);
    chk(nfall == nf + 1, "R9 single frame for two starts", nfall - nf, 1);

    // R8 start held: exact gap between back-to-back frames
    nf = ndone;
    cmd = 32'h1357_9BDF; stat = 32'h2468_ACE0; start = 1'b1;
    while (ndone == nf) @(negedge clk);
    gap_mode = 1'b1;
    while (ndone == nf + 1) @(negedge clk);
    start = 1'b0;
    gap_mode = 1'b0;
    nf = nfall;
    repeat (IDLE + 30) @(negedge clk);
    chk(nfall == nf, "R9 R8 no frame after start drops", nfall - nf, 0);

    summary();
    $finish;
  end

endmodule